// File: doc/BRIEF.md
# Ethernet MAC Run Controller

This block decides when an Ethernet MAC may move data and how it shuts down. A small control register holds an enable bit and a self-clearing hard-reset bit. The block turns writes to that register into one-cycle strobes. These strobes reset the whole core, clear the DMA and descriptor pointers, and end any FIFO read or write that is in progress. When the enable bit is cleared while a frame is on the wire, the block also sends a transmit-error pulse to the PHY.

There is a second, gentler way to halt the MAC, and it works for each path on its own. Each datapath (index 0 is transmit, index 1 is receive) reports whether it is inside a frame. A stop request lets the current frame finish and then holds back new frames. A sticky stop-complete flag reports that the path has halted. Removing the request resumes the path at once, with no reset and no change to the enable bit. The datapaths begin a new frame only while their start-permit output is high. Application writes into the transmit FIFO are accepted only while the MAC is enabled.

Top module: `mac_run_ctrl`

## Requirements
- R1: Writing ctl_wdata bit 0 = 1 raises mac_core_rst and read-back bit 0 for exactly the one cycle after the write. Both then drop by themselves, and the enable bit reads 0.
- R2: A write with bit 0 = 0 loads bit 1 into the enable bit. From the next cycle, read-back bit 1 shows the new value.
- R3: A write that clears the enable bit while it is set pulses dma_rst, fifo_wr_abort and fifo_rd_abort together, for one cycle, in the cycle after the write.
- R4: phy_tx_err pulses for one cycle after such a disabling write only if path_busy[0] was high when the write was sampled. It is never raised otherwise.
- R5: app_wr_accept equals app_wr_valid while the MAC is enabled and no hard reset is in progress. Otherwise application writes are dropped and app_wr_accept is 0.
- R6: A stop request on an idle path clears that path's start_ok in the same cycle and sets its stop_done in the next cycle.
- R7: A stop request on a busy path holds start_ok low and leaves stop_done at 0 until the frame ends. stop_done rises in the cycle after path_busy falls.
- R8: Dropping the stop request clears stop_done and restores start_ok in the next cycle, with the enable bit unchanged.
- R9: Hard reset outranks disable. A write with bit 0 = 1 and bit 1 = 0 gives mac_core_rst only, with no dma_rst and no phy_tx_err.
- R10: Disable outranks graceful stop. A disabling write clears stop_done in the next cycle, even when a frame boundary falls in the same cycle. stop_done stays 0 while the MAC is disabled.
- R11: The two paths stop on their own. A request on one path leaves the other path's start_ok and stop_done unchanged.
- R12: Control writes made during the hard-reset cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Write data: bit 0 hard reset, bit 1 enable |
| ctl_rdata | output | 2 | Read-back: bit 0 hard reset active, bit 1 enable |
| path_busy | input | NPATH | Per-path frame-in-progress level (0 = transmit) |
| stop_req | input | NPATH | Per-path graceful stop request |
| stop_done | output | NPATH | Per-path sticky stop-complete status |
| start_ok | output | NPATH | Per-path permit to begin a new frame |
| app_wr_valid | input | 1 | Application FIFO write request |
| app_wr_accept | output | 1 | Application write accepted |
| mac_core_rst | output | 1 | One-cycle reset of the whole core |
| dma_rst | output | 1 | One-cycle DMA, descriptor and pointer reset |
| fifo_wr_abort | output | 1 | One-cycle end of the current FIFO write |
| fifo_rd_abort | output | 1 | One-cycle end of the current FIFO read |
| phy_tx_err | output | 1 | One-cycle transmit error to the PHY |

## Verification
In one cycle the transmit path can finish its frame while the MAC is being disabled. The same clock edge could then both complete a graceful stop and start the abort. The bench drops path_busy[0] in the very cycle that carries the disabling write, with a stop request pending. It expects the abort strobes, no stop_done, and no phy_tx_err, because the frame had already ended at that edge. A second overlap writes hard reset and disable together while a frame is running. The bench expects only the core reset.

// File: rtl/mac_run_pkg.sv
package mac_run_pkg;

    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_DRAIN = 2'd1,
        GS_HALT  = 2'd2
    } gs_state_e;

    typedef struct packed {
        logic en;
        logic hrst;
    } ctl_regs_t;

    typedef struct packed {
        logic dma;
        logic wr_ab;
        logic rd_ab;
        logic tx_err;
    } abort_t;

endpackage

// File: rtl/mac_run_ctlreg.sv
module mac_run_ctlreg #(
    parameter int HRST_BIT = 0,
    parameter int EN_BIT   = 1,
    parameter int CTL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output logic             en_q_o,
    output logic             en_next_o,
    output logic             hrst_o,
    output logic             dis_evt_o
);
    import mac_run_pkg::*;

    ctl_regs_t r_d, r_q;
    logic      dis_evt;

    always_comb begin
        r_d     = r_q;
        r_d.hrst = 1'b0;
        dis_evt = 1'b0;
        if (!r_q.hrst && wr) begin
            if (wdata[HRST_BIT]) begin
                r_d.hrst = 1'b1;
                r_d.en   = 1'b0;
            end else begin
                r_d.en  = wdata[EN_BIT];
                dis_evt = r_q.en && !wdata[EN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata           = '0;
        rdata[HRST_BIT] = r_q.hrst;
        rdata[EN_BIT]   = r_q.en;
    end

    assign en_q_o    = r_q.en;
    assign en_next_o = r_d.en;
    assign hrst_o    = r_q.hrst;
    assign dis_evt_o = dis_evt;

    p_hrst_selfclr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hrst |=> !r_q.hrst);
    p_hrst_no_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hrst |-> !r_q.en);
    p_hrst_ignores_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hrst |=> !r_q.en);
endmodule

// File: rtl/mac_run_abort.sv
module mac_run_abort (
    input  logic clk,
    input  logic rst_n,
    input  logic dis_evt,
    input  logic tx_busy,
    output logic dma_rst,
    output logic fifo_wr_abort,
    output logic fifo_rd_abort,
    output logic phy_tx_err
);
    import mac_run_pkg::*;

    abort_t a_d, a_q;

    always_comb begin
        a_d        = '0;
        a_d.dma    = dis_evt;
        a_d.wr_ab  = dis_evt;
        a_d.rd_ab  = dis_evt;
        a_d.tx_err = dis_evt && tx_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign dma_rst       = a_q.dma;
    assign fifo_wr_abort = a_q.wr_ab;
    assign fifo_rd_abort = a_q.rd_ab;
    assign phy_tx_err    = a_q.tx_err;

    p_txerr_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.tx_err |-> $past(tx_busy));
    p_txerr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.tx_err |=> !a_q.tx_err);
    p_dma_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.dma |=> !a_q.dma);
endmodule

// File: rtl/mac_run_gstop.sv
module mac_run_gstop (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic en_next,
    input  logic req,
    input  logic busy,
    output logic done,
    output logic start_ok
);
    import mac_run_pkg::*;

    gs_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_next) begin
            st_d = GS_RUN;
        end else begin
            unique case (st_q)
                GS_RUN:   if (req) st_d = busy ? GS_DRAIN : GS_HALT;
                GS_DRAIN: if (!req) st_d = GS_RUN;
                          else if (!busy) st_d = GS_HALT;
                GS_HALT:  if (!req) st_d = GS_RUN;
                default:  st_d = GS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GS_RUN;
        else        st_q <= st_d;
    end

    assign done     = (st_q == GS_HALT);
    assign start_ok = en_q && (st_q == GS_RUN) && !req;

    p_done_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req));
    p_done_after_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(busy));
    p_no_start_when_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !start_ok);
    p_off_clears_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !done);
endmodule

// File: rtl/mac_run_ctrl.sv
module mac_run_ctrl #(
    parameter int NPATH    = 2,
    parameter int TX_IDX   = 0,
    parameter int HRST_BIT = 0,
    parameter int EN_BIT   = 1,
    localparam int CTL_W   = ((HRST_BIT > EN_BIT) ? HRST_BIT : EN_BIT) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic [NPATH-1:0] path_busy,
    input  logic [NPATH-1:0] stop_req,
    output logic [NPATH-1:0] stop_done,
    output logic [NPATH-1:0] start_ok,
    input  logic             app_wr_valid,
    output logic             app_wr_accept,
    output logic             mac_core_rst,
    output logic             dma_rst,
    output logic             fifo_wr_abort,
    output logic             fifo_rd_abort,
    output logic             phy_tx_err
);
    logic en_q, en_next, hrst, dis_evt;

    mac_run_ctlreg #(
        .HRST_BIT(HRST_BIT),
        .EN_BIT  (EN_BIT),
        .CTL_W   (CTL_W)
    ) u_ctlreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .rdata    (ctl_rdata),
        .en_q_o   (en_q),
        .en_next_o(en_next),
        .hrst_o   (hrst),
        .dis_evt_o(dis_evt)
    );

    mac_run_abort u_abort (
        .clk          (clk),
        .rst_n        (rst_n),
        .dis_evt      (dis_evt),
        .tx_busy      (path_busy[TX_IDX]),
        .dma_rst      (dma_rst),
        .fifo_wr_abort(fifo_wr_abort),
        .fifo_rd_abort(fifo_rd_abort),
        .phy_tx_err   (phy_tx_err)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        mac_run_gstop u_gstop (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_q    (en_q),
            .en_next (en_next),
            .req     (stop_req[g]),
            .busy    (path_busy[g]),
            .done    (stop_done[g]),
            .start_ok(start_ok[g])
        );
    end

    assign mac_core_rst  = hrst;
    assign app_wr_accept = app_wr_valid && en_q && !hrst;

    p_accept_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        app_wr_accept |-> (app_wr_valid && ctl_rdata[EN_BIT]));
    p_hrst_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mac_core_rst |-> (!dma_rst && !phy_tx_err));
endmodule

// File: tb/mac_run_ctrl_tb_top.sv
module mac_run_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_wdata = '0;
    logic [1:0] ctl_rdata;
    logic [1:0] path_busy = '0;
    logic [1:0] stop_req = '0;
    logic [1:0] stop_done;
    logic [1:0] start_ok;
    logic       app_wr_valid = 1'b0;
    logic       app_wr_accept, mac_core_rst, dma_rst;
    logic       fifo_wr_abort, fifo_rd_abort, phy_tx_err;

    always #4 clk = ~clk;

    mac_run_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_wdata    (ctl_wdata),
        .ctl_rdata    (ctl_rdata),
        .path_busy    (path_busy),
        .stop_req     (stop_req),
        .stop_done    (stop_done),
        .start_ok     (start_ok),
        .app_wr_valid (app_wr_valid),
        .app_wr_accept(app_wr_accept),
        .mac_core_rst (mac_core_rst),
        .dma_rst      (dma_rst),
        .fifo_wr_abort(fifo_wr_abort),
        .fifo_rd_abort(fifo_rd_abort),
        .phy_tx_err   (phy_tx_err)
    );

    localparam logic [11:0] B_TXE = 12'h001;
    localparam logic [11:0] B_RAB = 12'h002;
    localparam logic [11:0] B_WAB = 12'h004;
    localparam logic [11:0] B_DMA = 12'h008;
    localparam logic [11:0] B_HRS = 12'h010;
    localparam logic [11:0] B_ACC = 12'h020;
    localparam logic [11:0] B_SO0 = 12'h040;
    localparam logic [11:0] B_SO1 = 12'h080;
    localparam logic [11:0] B_SD0 = 12'h100;
    localparam logic [11:0] B_SD1 = 12'h200;
    localparam logic [11:0] B_RDH = 12'h400;
    localparam logic [11:0] B_RDE = 12'h800;

    logic [11:0] outv;
    assign outv = {ctl_rdata[1], ctl_rdata[0], stop_done[1], stop_done[0],
                   start_ok[1], start_ok[0], app_wr_accept, mac_core_rst,
                   dma_rst, fifo_wr_abort, fifo_rd_abort, phy_tx_err};

    typedef struct {
        int          cyc;
        logic [11:0] mask;
        logic [11:0] val;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input logic wr, input logic [1:0] wd, input logic [1:0] busy,
                        input logic [1:0] req, input logic av);
        @(negedge clk);
        ctl_wr       = wr;
        ctl_wdata    = wd;
        path_busy    = busy;
        stop_req     = req;
        app_wr_valid = av;
    endtask

    task automatic want(input int dly, input logic [11:0] m, input logic [11:0] v,
                        input string tag);
        exp_t e;
        e.cyc  = cyc + dly;
        e.mask = m;
        e.val  = v;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #3;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    n_chk++;
                    if ((outv & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
                        n_fail++;
                        $display("FAIL %s cycle %0d: actual %03h expected %03h (mask %03h)",
                                 sb[i].tag, cyc, outv & sb[i].mask,
                                 sb[i].val & sb[i].mask, sb[i].mask);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(0, 2'b00, 2'b00, 2'b00, 0);
        want(0, 12'hFFF, 12'h000, "reset state");

        // R2: enable
        tick(1, 2'b10, 2'b00, 2'b00, 0);
        want(0, B_RDE, 12'h000, "R2 before");
        want(1, B_RDE | B_SO0 | B_SO1, B_RDE | B_SO0 | B_SO1, "R2");
        tick(0, 2'b00, 2'b00, 2'b00, 1);
        want(0, B_ACC, B_ACC, "R5 enabled");

        // R6 / R11: idle stop on transmit
        tick(0, 2'b00, 2'b00, 2'b01, 0);
        want(0, B_SO0 | B_SO1, B_SO1, "R6 start_ok");
        want(1, B_SD0, B_SD0, "R6 done");
        want(1, B_SD1 | B_SO1, B_SO1, "R11");
        tick(0, 2'b00, 2'b00, 2'b01, 0);

        // R8: resume
        tick(0, 2'b00, 2'b00, 2'b00, 0);
        want(0, B_SD0 | B_SO0, B_SD0, "R8 same cycle");
        want(1, B_SD0 | B_SO0 | B_RDE, B_SO0 | B_RDE, "R8");

        // R7: receive drains a frame first
        tick(0, 2'b00, 2'b10, 2'b10, 0);
        want(0, B_SO1, 12'h000, "R7 start_ok");
        want(1, B_SD1, 12'h000, "R7 busy");
        tick(0, 2'b00, 2'b10, 2'b10, 0);
        want(1, B_SD1, 12'h000, "R7 still busy");
        tick(0, 2'b00, 2'b00, 2'b10, 0);
        want(1, B_SD1 | B_SO1, B_SD1, "R7 boundary");
        tick(0, 2'b00, 2'b00, 2'b10, 0);
        tick(0, 2'b00, 2'b00, 2'b00, 0);
        tick(0, 2'b00, 2'b00, 2'b00, 0);

        // R10 / R3: disable on the very cycle the tx frame ends
        tick(0, 2'b00, 2'b01, 2'b01, 0);
        tick(1, 2'b00, 2'b00, 2'b01, 1);
        want(0, B_ACC, B_ACC, "R5 before disable");
        want(1, B_SD0, 12'h000, "R10 overlap");
        want(1, B_DMA | B_WAB | B_RAB, B_DMA | B_WAB | B_RAB, "R3");
        want(1, B_TXE, 12'h000, "R4 idle at write");
        want(1, B_ACC | B_RDE, 12'h000, "R5 disabled");
        tick(0, 2'b00, 2'b00, 2'b01, 1);
        want(1, B_DMA | B_WAB | B_RAB | B_SD0, 12'h000, "R3 one cycle");
        tick(0, 2'b00, 2'b00, 2'b00, 0);

        // R4: disable mid-frame
        tick(1, 2'b10, 2'b00, 2'b00, 0);
        tick(0, 2'b00, 2'b01, 2'b00, 0);
        tick(1, 2'b00, 2'b01, 2'b00, 0);
        want(1, B_TXE | B_DMA, B_TXE | B_DMA, "R4 abort");
        tick(0, 2'b00, 2'b01, 2'b00, 0);
        want(1, B_TXE, 12'h000, "R4 one cycle");
        tick(0, 2'b00, 2'b00, 2'b00, 0);

        // R9 / R1 / R12: hard reset together with disable
        tick(1, 2'b10, 2'b00, 2'b00, 0);
        tick(0, 2'b00, 2'b01, 2'b00, 0);
        tick(1, 2'b01, 2'b01, 2'b00, 0);
        want(1, B_HRS | B_RDH | B_DMA | B_TXE | B_RDE, B_HRS | B_RDH, "R9");
        tick(1, 2'b10, 2'b01, 2'b00, 1);
        want(0, B_ACC, 12'h000, "R5 hard reset");
        want(1, B_HRS | B_RDH, 12'h000, "R1 self-clear");
        want(1, B_RDE, 12'h000, "R12");
        tick(0, 2'b00, 2'b00, 2'b00, 0);

        // R10: disable clears a completed stop
        tick(1, 2'b10, 2'b00, 2'b00, 0);
        tick(0, 2'b00, 2'b00, 2'b10, 0);
        want(1, B_SD1, B_SD1, "R6 rx idle");
        tick(1, 2'b00, 2'b00, 2'b10, 0);
        want(0, B_SD1, B_SD1, "R10 before");
        want(1, B_SD1, 12'h000, "R10 cleared");
        tick(0, 2'b00, 2'b00, 2'b00, 0);

        repeat (3) tick(0, 2'b00, 2'b00, 2'b00, 0);
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        finish_run();
    end

endmodule